// File: doc/BRIEF.md
# Power-of-Two Coefficient Quantize/Dequantize Unit

This unit sits between a two-dimensional forward transform and its inverse. It accepts one signed transform coefficient per clock, in row-major order across an 8×8 block. For each coefficient it produces two results: the quantized level, which is the coefficient divided by a position-dependent step with rounding, and the reconstructed coefficient, which is that level multiplied back by the same step. Every step is a fixed power of two. The division is therefore a rounded arithmetic right shift, the multiplication is a left shift, and no divider or multiplier is built.

Two fixed step tables are built into the logic, one for luminance and one for chrominance. The chrominance table is one octave coarser. A single select input picks the table for a whole block. An internal 6-bit position counter tracks where in the block the current coefficient falls. Coefficients are 20-bit two's complement values with 7 fractional bits; the fractional point does not affect the arithmetic.

Top module: `qd_pow2_unit`

## Requirements
- R1: While reset is asserted and right after it, `valid_o` and `blk_done_o` are 0 and `level_o` and `recon_o` are 0.
- R2: With shift s for the current position, `level_o` = sign(x)·((|x| + 2^(s−1)) >> s). Exact halves therefore round away from zero, and a negative input whose magnitude rounds to 0 gives level 0.
- R3: `recon_o` = `level_o`·2^s, saturated to the 20-bit range [−524288, 524287].
- R4: Position p = 8·row + col counts coefficients in arrival order from 0. The luminance shift is min(7, 3 + floor((row+col)/2)), so it runs from 3 at position 0 up to 7.
- R5: The chrominance shift is min(7, 4 + floor((row+col)/2)).
- R6: `chroma_i` is sampled together with the coefficient at position 0: 1 selects chrominance and 0 selects luminance. That choice holds for the whole block. Changes of `chroma_i` at positions 1 to 63, or on idle cycles, have no effect on the results.
- R7: For each cycle with `coef_valid_i` high, `valid_o` is high on the next cycle, carrying the results for that coefficient.
- R8: The position advances only on valid input and wraps after 63. `blk_done_o` is high exactly with the output of position 63, and the next valid coefficient starts a new block at position 0.
- R9: On a cycle after one without valid input, `valid_o` and `blk_done_o` are 0. `level_o` and `recon_o` keep their last values, and the position does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_valid_i | input | 1 | Coefficient present this cycle |
| coef_i | input | 20 | Signed input coefficient |
| chroma_i | input | 1 | Table select, sampled at block start (1 = chrominance) |
| level_o | output | 20 | Signed quantized level |
| recon_o | output | 20 | Signed dequantized coefficient |
| valid_o | output | 1 | Results valid |
| blk_done_o | output | 1 | Results belong to the last position of a block |

## Verification
Every result is due exactly one clock after the cycle in which its coefficient was accepted. This covers the level, the reconstruction, the valid flag and the block-done flag, because the only register on the path is the output stage. Each scenario task drives inputs on the falling edge. It then waits for the next rising edge and samples shortly after it. A coefficient's results are therefore compared in the same task call that applied it, against a model that tracks the position and the latched table select. Idle cycles between coefficients are sampled the same way, to confirm that valid is low, the outputs hold, and a toggled select or a changed coefficient leaves no trace.

// File: rtl/qd_pow2_pkg.sv
`timescale 1ns/1ps
package qd_pow2_pkg;
   // Shift for a diagonal distance from the DC term, capped at a maximum.
   function automatic int unsigned qd_diag_shift(input int unsigned base,
                                                  input int unsigned row,
                                                  input int unsigned col,
                                                  input int unsigned cap);
      int unsigned s;
      s = base + (row + col) / 2;
      return (s > cap) ? cap : s;
   endfunction
endpackage

// File: rtl/qd_shift_lut.sv
`timescale 1ns/1ps
module qd_shift_lut
   import qd_pow2_pkg::*;
#(
   parameter int unsigned BLK_DIM     = 8,
   parameter int unsigned LUMA_BASE   = 3,
   parameter int unsigned CHROMA_BASE = 4,
   parameter int unsigned SHIFT_MAX   = 7,
   localparam int unsigned NPOS  = BLK_DIM * BLK_DIM,
   localparam int unsigned POS_W = $clog2(NPOS),
   localparam int unsigned SH_W  = $clog2(SHIFT_MAX + 1)
) (
   input  logic [POS_W-1:0] pos_i,
   input  logic             chroma_i,
   output logic [SH_W-1:0]  shift_o
);
   logic [SH_W-1:0] luma_tab   [NPOS];
   logic [SH_W-1:0] chroma_tab [NPOS];

   for (genvar p = 0; p < NPOS; p++) begin : g_ent
      localparam int unsigned ROW = p / BLK_DIM;
      localparam int unsigned COL = p % BLK_DIM;
      localparam int unsigned LS  = qd_diag_shift(LUMA_BASE, ROW, COL, SHIFT_MAX);
      localparam int unsigned CS  = qd_diag_shift(CHROMA_BASE, ROW, COL, SHIFT_MAX);
      assign luma_tab[p]   = SH_W'(LS);
      assign chroma_tab[p] = SH_W'(CS);
   end

   always_comb begin
      if (chroma_i) shift_o = chroma_tab[pos_i];
      else          shift_o = luma_tab[pos_i];
   end
endmodule

// File: rtl/qd_round_shift.sv
`timescale 1ns/1ps
module qd_round_shift #(
   parameter int unsigned DATA_W    = 20,
   parameter int unsigned SHIFT_MAX = 7,
   localparam int unsigned SH_W  = $clog2(SHIFT_MAX + 1),
   localparam int unsigned SUM_W = DATA_W + 2
) (
   input  logic [DATA_W-1:0] coef_i,
   input  logic [SH_W-1:0]   shift_i,
   output logic [DATA_W-1:0] level_o,
   output logic [DATA_W-1:0] recon_o
);
   localparam logic [SUM_W-1:0] POS_LIM = (SUM_W'(1) << (DATA_W - 1)) - SUM_W'(1);
   localparam logic [SUM_W-1:0] NEG_LIM = SUM_W'(1) << (DATA_W - 1);

   logic              neg;
   logic [SUM_W-1:0]  ext;
   logic [SUM_W-1:0]  mag;
   logic [SUM_W-1:0]  half;
   logic [SUM_W-1:0]  sum;
   logic [DATA_W-1:0] qmag;
   logic [SUM_W-1:0]  rmag;

   always_comb begin
      neg  = coef_i[DATA_W-1];
      ext  = {{2{coef_i[DATA_W-1]}}, coef_i};
      mag  = neg ? (~ext + SUM_W'(1)) : ext;
      half = (SUM_W'(1) << shift_i) >> 1;
      sum  = mag + half;
      qmag = DATA_W'(sum >> shift_i);
      rmag = SUM_W'(qmag) << shift_i;

      level_o = neg ? (~qmag + DATA_W'(1)) : qmag;

      if (!neg && (rmag > POS_LIM))
         recon_o = {1'b0, {(DATA_W-1){1'b1}}};
      else if (neg && (rmag > NEG_LIM))
         recon_o = {1'b1, {(DATA_W-1){1'b0}}};
      else if (neg)
         recon_o = DATA_W'(~rmag + SUM_W'(1));
      else
         recon_o = DATA_W'(rmag);
   end
endmodule

// File: rtl/qd_blk_ctrl.sv
`timescale 1ns/1ps
module qd_blk_ctrl #(
   parameter int unsigned POS_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic             chroma_i,
   output logic [POS_W-1:0] pos_o,
   output logic             chroma_eff_o,
   output logic             last_o
);
   logic [POS_W-1:0] pos_q;
   logic             chroma_q;
   logic             at_start;

   assign at_start     = (pos_q == '0);
   assign pos_o        = pos_q;
   assign chroma_eff_o = at_start ? chroma_i : chroma_q;
   assign last_o       = &pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= '0;
         chroma_q <= 1'b0;
      end else if (valid_i) begin
         pos_q <= pos_q + POS_W'(1);
         if (at_start) chroma_q <= chroma_i;
      end
   end
endmodule

// File: rtl/qd_pow2_unit.sv
`timescale 1ns/1ps
module qd_pow2_unit #(
   parameter int unsigned DATA_W      = 20,
   parameter int unsigned BLK_DIM     = 8,
   parameter int unsigned LUMA_BASE   = 3,
   parameter int unsigned CHROMA_BASE = 4,
   parameter int unsigned SHIFT_MAX   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coef_valid_i,
   input  logic [DATA_W-1:0] coef_i,
   input  logic              chroma_i,
   output logic [DATA_W-1:0] level_o,
   output logic [DATA_W-1:0] recon_o,
   output logic              valid_o,
   output logic              blk_done_o
);
   localparam int unsigned NPOS  = BLK_DIM * BLK_DIM;
   localparam int unsigned POS_W = $clog2(NPOS);
   localparam int unsigned SH_W  = $clog2(SHIFT_MAX + 1);

   if (LUMA_BASE < 1 || CHROMA_BASE < 1) begin : g_bad_base
      $error("step shifts must be at least 1");
   end
   if (LUMA_BASE > SHIFT_MAX || CHROMA_BASE > SHIFT_MAX) begin : g_bad_cap
      $error("base shift exceeds the shift cap");
   end
   if (SHIFT_MAX + 2 >= DATA_W) begin : g_bad_width
      $error("data width too small for the largest step");
   end
   if ((1 << POS_W) != NPOS) begin : g_bad_dim
      $error("block dimension must be a power of two");
   end

   logic [POS_W-1:0]  pos;
   logic              chroma_eff;
   logic              last_pos;
   logic [SH_W-1:0]   shift;
   logic [DATA_W-1:0] lvl_c;
   logic [DATA_W-1:0] rec_c;

   qd_blk_ctrl #(.POS_W(POS_W)) ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .valid_i      (coef_valid_i),
      .chroma_i     (chroma_i),
      .pos_o        (pos),
      .chroma_eff_o (chroma_eff),
      .last_o       (last_pos)
   );

   qd_shift_lut #(
      .BLK_DIM     (BLK_DIM),
      .LUMA_BASE   (LUMA_BASE),
      .CHROMA_BASE (CHROMA_BASE),
      .SHIFT_MAX   (SHIFT_MAX)
   ) lut_i (
      .pos_i    (pos),
      .chroma_i (chroma_eff),
      .shift_o  (shift)
   );

   qd_round_shift #(.DATA_W(DATA_W), .SHIFT_MAX(SHIFT_MAX)) rnd_i (
      .coef_i  (coef_i),
      .shift_i (shift),
      .level_o (lvl_c),
      .recon_o (rec_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o    <= 1'b0;
         blk_done_o <= 1'b0;
         level_o    <= '0;
         recon_o    <= '0;
      end else begin
         valid_o    <= coef_valid_i;
         blk_done_o <= coef_valid_i & last_pos;
         if (coef_valid_i) begin
            level_o <= lvl_c;
            recon_o <= rec_c;
         end
      end
   end
endmodule

// File: rtl/qd_pow2_unit_chk.sv
`timescale 1ns/1ps
module qd_pow2_unit_chk #(
   parameter int unsigned DATA_W = 20,
   parameter int unsigned POS_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              coef_valid_i,
   input logic [DATA_W-1:0] level_o,
   input logic [DATA_W-1:0] recon_o,
   input logic              valid_o,
   input logic              blk_done_o
);
   logic [POS_W-1:0] out_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       out_cnt <= '0;
      else if (valid_o) out_cnt <= out_cnt + POS_W'(1);
   end

   a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      coef_valid_i |=> valid_o);

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !coef_valid_i |=> (!valid_o && !blk_done_o && $stable(level_o) && $stable(recon_o)));

   a_r8_done_at_last: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (blk_done_o == (out_cnt == '1)));

   a_r8_done_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      blk_done_o |-> valid_o);

   a_r3_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && level_o == '0) |-> (recon_o == '0));

   a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && level_o != '0) |-> (recon_o[DATA_W-1] == level_o[DATA_W-1] && recon_o != '0));
endmodule

bind qd_pow2_unit qd_pow2_unit_chk #(.DATA_W(DATA_W), .POS_W(POS_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .coef_valid_i (coef_valid_i),
   .level_o      (level_o),
   .recon_o      (recon_o),
   .valid_o      (valid_o),
   .blk_done_o   (blk_done_o)
);

// File: tb/qd_pow2_unit_tb_top.sv
`timescale 1ns/1ps
module qd_pow2_unit_tb_top;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               vld = 1'b0;
   logic [19:0]        coef = '0;
   logic               chroma = 1'b0;
   logic signed [19:0] level_o;
   logic signed [19:0] recon_o;
   logic               valid_o;
   logic               blk_done_o;

   int n_chk  = 0;
   int n_fail = 0;
   int mpos   = 0;
   bit mch    = 1'b0;
   longint prev_l = 0;
   longint prev_r = 0;

   always #2 clk = ~clk;

   qd_pow2_unit dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .coef_valid_i (vld),
      .coef_i       (coef),
      .chroma_i     (chroma),
      .level_o      (level_o),
      .recon_o      (recon_o),
      .valid_o      (valid_o),
      .blk_done_o   (blk_done_o)
   );

   function automatic int exp_shift(input int p, input bit c);
      int s;
      s = (c ? 4 : 3) + ((p / 8) + (p % 8)) / 2;
      return (s > 7) ? 7 : s;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (pos %0d)", req, act, exp, mpos);
      end
   endtask

   task automatic push(input longint x, input bit sel, input int gap, input string req);
      longint mag, q, el, er;
      int s;
      bit ed;
      @(negedge clk);
      coef = x[19:0]; chroma = sel; vld = 1'b1;
      if (mpos == 0) mch = sel;
      s   = exp_shift(mpos, mch);
      mag = (x < 0) ? -x : x;
      q   = (mag + (64'sd1 <<< (s - 1))) >>> s;
      el  = (x < 0) ? -q : q;
      er  = el * (64'sd1 <<< s);
      if (er > 524287)  er = 524287;
      if (er < -524288) er = -524288;
      ed  = (mpos == 63);
      @(posedge clk); #1;
      check("R7 valid", valid_o, 1);
      check(req, level_o, el);
      check("R3 recon", recon_o, er);
      check("R8 done", blk_done_o, ed);
      mpos = (mpos + 1) % 64;
      prev_l = el; prev_r = er;
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         vld = 1'b0; chroma = ~chroma; coef = ~coef;
         @(posedge clk); #1;
         check("R9 idle valid", valid_o, 0);
         check("R9 idle done", blk_done_o, 0);
         check("R9 hold level", level_o, prev_l);
         check("R9 hold recon", recon_o, prev_r);
      end
   endtask

   task automatic go_idle();
      @(negedge clk); vld = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 valid", valid_o, 0);
      check("R1 done", blk_done_o, 0);
      check("R1 level", level_o, 0);
      check("R1 recon", recon_o, 0);
   endtask

   // R2/R4: luminance block, with ties of exactly one half at the first two positions
   task automatic t_luma_block();
      for (int p = 0; p < 64; p++) begin
         longint x;
         x = ((p * 7919) % 4001) - 2000;
         if (p == 0) x = 12;
         if (p == 1) x = -12;
         if (p == 2) x = -7;
         push(x, 1'b0, 0, "R4 luma level");
      end
      go_idle();
   endtask

   // R5/R6: chrominance block, with the select toggling after the first coefficient
   task automatic t_chroma_switch();
      for (int p = 0; p < 64; p++) begin
         longint x;
         x = 3000 - ((p * 613) % 6007);
         push(x, (p == 0) ? 1'b1 : p[0], 0, "R6 chroma level");
      end
      go_idle();
   endtask

   // R9: gaps between coefficients must not move the position or disturb the outputs
   task automatic t_gaps();
      for (int p = 0; p < 64; p++) begin
         longint x;
         x = (p[0] ? -1 : 1) * (p * 211 + 5);
         push(x, 1'b0, p % 3, "R9 gapped level");
      end
      go_idle();
   endtask

   // R2/R3: exact-half ties at every shift, plus full-scale inputs that saturate
   task automatic t_extremes(input bit sel);
      for (int p = 0; p < 64; p++) begin
         longint x;
         int s;
         s = exp_shift(p, sel);
         x = (p[0] ? -3 : 3) * (64'sd1 <<< (s - 1));
         if (p == 0 || p == 63) x = 524287;
         if (p == 1 || p == 62) x = -524288;
         if (p == 5) x = -((64'sd1 <<< (s - 1)) - 1);
         push(x, sel, 0, "R2 tie/extreme level");
      end
      go_idle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1 t_reset();
      t_luma_block();
      t_chroma_switch();
      t_gaps();
      t_extremes(1'b0);
      t_extremes(1'b1);
      repeat (2) @(posedge clk);
      #1 check("R9 final idle", valid_o, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule